// File: doc/BRIEF.md
# Bidirectional Handshake Strobe Forwarder

This block sits between two segments, side A and side B, of a bus expander. It relays the request and acknowledge handshake strobes from whichever side is sending to the other side. Each strobe can travel A to B or B to A. A direction enable for each direction, driven by an external bus-phase state machine, decides which way a strobe may travel. Strobe levels come in active low and pass through a two-flop synchronizer. The block drives each side only through pull-down enables, so a high output means "pull this line low".

The two directions shape pulses differently. A to B runs a leading-edge hold. Once the output asserts, it keeps its level for `HOLD_CYC` cycles whatever the input does. After that it tracks the input. B to A runs a minimum-width stretcher. Every forwarded pulse lasts at least `MIN_W` cycles, even if the input pulse or the direction enable goes away sooner. The block drops any assertion that it is driving itself on the source side, as reported by a per-side self-drive flag.

Each direction of each strobe has its own small state machine:
- A-to-B path states:
  - `HOLD_IDLE`: output off.
  - `HOLD_LOCK`: output on, hold window counting.
  - `HOLD_FOLLOW`: output tracks the input.
  - Transitions: idle→lock on a qualified assertion. Lock→follow at the end of the window if the input is still asserted. Lock→idle at the end of the window if the input is released, or at any time the enable drops. Follow→idle when the qualified input releases.
- B-to-A path states:
  - `STR_IDLE`: output off.
  - `STR_STRETCH`: output on, minimum-width window counting, enable ignored.
  - `STR_TRACK`: output tracks the input.
  - Transitions: idle→stretch on a qualified assertion. Stretch→track at the end of the window if the input is still asserted, otherwise stretch→idle. Track→idle when the qualified input releases.

Top module: `hs_strobe_fwd`

## Requirements
- R1: Strobe index 0 is request and index 1 is acknowledge. Each is forwarded A to B (input `a_strobe_n`, output `b_pull_dn`) and B to A (input `b_strobe_n`, output `a_pull_dn`). An input driven low becomes visible at the output on the third rising clock edge after it is applied.
- R2: An assertion is forwarded only while the direction enable for that direction is high. With the enable low, the output stays 0.
- R3: An assertion arriving while the self-drive flag of the source side is 1 is not forwarded.
- R4: A to B: once the output asserts, it stays at 1 for at least `HOLD_CYC` cycles (default 6) even if the input releases. A 1-cycle input gives exactly `HOLD_CYC` cycles of output.
- R5: B to A: every forwarded pulse lasts at least `MIN_W` cycles (default 5). This holds even if the input or the direction enable drops earlier.
- R6: If both direction enables of one strobe are high at the same time, neither direction forwards that strobe.
- R7: An input pulse longer than the hold or stretch window gives an output of the same width in both directions. The output releases three edges after the input releases.
- R8: Reset is asynchronous and active low. It forces every pull-down enable to 0 immediately, including in the middle of a pulse.
- R9: A to B: if the direction enable drops during the hold window, the output releases on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_strobe_n | input | NUM_STROBES | Sampled side-A strobe levels, active low (bit 0 request, bit 1 acknowledge) |
| b_strobe_n | input | NUM_STROBES | Sampled side-B strobe levels, active low |
| a_self_drv | input | NUM_STROBES | This chip is driving the side-A strobe |
| b_self_drv | input | NUM_STROBES | This chip is driving the side-B strobe |
| dir_a2b | input | NUM_STROBES | Direction enable, A to B |
| dir_b2a | input | NUM_STROBES | Direction enable, B to A |
| a_pull_dn | output | NUM_STROBES | Pull-down enable for the side-A strobe |
| b_pull_dn | output | NUM_STROBES | Pull-down enable for the side-B strobe |

## Verification
The bench builds the block with `HOLD_CYC` = 6, `MIN_W` = 5 and `NUM_STROBES` = 2. Because the two window lengths differ, a swapped shaper or a swapped strobe index shows up as an edge landing one cycle off. A one-cycle input pulse exposes the full hold and stretch windows. A seven-cycle pulse lands one cycle past the hold boundary, which separates the lock state from the follow state. Mid-window enable drops show that the hold path aborts while the stretcher does not.

// File: rtl/hs_strobe_fwd_pkg.sv
package hs_strobe_fwd_pkg;

    typedef enum logic [1:0] {
        HOLD_IDLE   = 2'd0,
        HOLD_LOCK   = 2'd1,
        HOLD_FOLLOW = 2'd2
    } hold_st_e;

    typedef enum logic [1:0] {
        STR_IDLE    = 2'd0,
        STR_STRETCH = 2'd1,
        STR_TRACK   = 2'd2
    } str_st_e;

endpackage

// File: rtl/hsf_sync.sv
module hsf_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_n,
    output logic [WIDTH-1:0] asserted
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Active-low level converted to active-high; reset reads as released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= ~lvl_n;
            sync_q <= meta_q;
        end
    end

    assign asserted = sync_q;
endmodule

// File: rtl/hsf_hold_path.sv
module hsf_hold_path
    import hs_strobe_fwd_pkg::*;
#(
    parameter int HOLD_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sensed,
    input  logic en,
    input  logic self_drv,
    output logic pull_dn
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam int AW = CW + 1;

    hold_st_e        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            qual;
    logic            out_q;

    assign qual = sensed & en & ~self_drv;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            HOLD_IDLE: begin
                if (qual) begin
                    st_d  = HOLD_LOCK;
                    cnt_d = CW'(HOLD_CYC - 1);
                end
            end
            HOLD_LOCK: begin
                if (!en) begin
                    st_d = HOLD_IDLE;
                end else if (cnt_q == '0) begin
                    st_d = qual ? HOLD_FOLLOW : HOLD_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            HOLD_FOLLOW: begin
                if (!qual) st_d = HOLD_IDLE;
            end
            default: st_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= HOLD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (st_d != HOLD_IDLE);
    end

    assign pull_dn = out_q;

    // Checker state: cycles the output has been high, saturating.
    logic [AW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      age_q <= '0;
        else if (!out_q)                 age_q <= '0;
        else if (age_q != {AW{1'b1}})    age_q <= age_q + 1'b1;
    end

    AST_HOLD_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> (age_q >= AW'(HOLD_CYC)) || !$past(en)); // R4
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_q); // R2
    AST_HOLD_SELF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q && self_drv) |=> !out_q); // R3
endmodule

// File: rtl/hsf_stretch_path.sv
module hsf_stretch_path
    import hs_strobe_fwd_pkg::*;
#(
    parameter int MIN_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sensed,
    input  logic en,
    input  logic self_drv,
    output logic pull_dn
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam int AW = CW + 1;

    str_st_e         st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            qual;
    logic            out_q;

    assign qual = sensed & en & ~self_drv;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            STR_IDLE: begin
                if (qual) begin
                    st_d  = STR_STRETCH;
                    cnt_d = CW'(MIN_W - 1);
                end
            end
            STR_STRETCH: begin
                if (cnt_q == '0) st_d = qual ? STR_TRACK : STR_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            STR_TRACK: begin
                if (!qual) st_d = STR_IDLE;
            end
            default: st_d = STR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= STR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (st_d != STR_IDLE);
    end

    assign pull_dn = out_q;

    logic [AW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      age_q <= '0;
        else if (!out_q)                 age_q <= '0;
        else if (age_q != {AW{1'b1}})    age_q <= age_q + 1'b1;
    end

    AST_STRETCH_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> (age_q >= AW'(MIN_W))); // R5
    AST_STRETCH_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q && !en) |=> !out_q); // R2
    AST_STRETCH_SELF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q && self_drv) |=> !out_q); // R3
endmodule

// File: rtl/hs_strobe_fwd.sv
module hs_strobe_fwd #(
    parameter int NUM_STROBES = 2,
    parameter int HOLD_CYC    = 6,
    parameter int MIN_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_STROBES-1:0] a_strobe_n,
    input  logic [NUM_STROBES-1:0] b_strobe_n,
    input  logic [NUM_STROBES-1:0] a_self_drv,
    input  logic [NUM_STROBES-1:0] b_self_drv,
    input  logic [NUM_STROBES-1:0] dir_a2b,
    input  logic [NUM_STROBES-1:0] dir_b2a,
    output logic [NUM_STROBES-1:0] a_pull_dn,
    output logic [NUM_STROBES-1:0] b_pull_dn
);
    logic [NUM_STROBES-1:0] a_seen;
    logic [NUM_STROBES-1:0] b_seen;
    logic [NUM_STROBES-1:0] en_fwd;
    logic [NUM_STROBES-1:0] en_rev;

    hsf_sync #(.WIDTH(NUM_STROBES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .lvl_n(a_strobe_n), .asserted(a_seen)
    );
    hsf_sync #(.WIDTH(NUM_STROBES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .lvl_n(b_strobe_n), .asserted(b_seen)
    );

    // Conflicting enables cancel each other.
    assign en_fwd = dir_a2b & ~dir_b2a;
    assign en_rev = dir_b2a & ~dir_a2b;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
        hsf_hold_path #(.HOLD_CYC(HOLD_CYC)) u_a2b (
            .clk(clk), .rst_n(rst_n), .sensed(a_seen[g]), .en(en_fwd[g]),
            .self_drv(a_self_drv[g]), .pull_dn(b_pull_dn[g])
        );
        hsf_stretch_path #(.MIN_W(MIN_W)) u_b2a (
            .clk(clk), .rst_n(rst_n), .sensed(b_seen[g]), .en(en_rev[g]),
            .self_drv(b_self_drv[g]), .pull_dn(a_pull_dn[g])
        );

        AST_CONFLICT_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_a2b[g] && dir_b2a[g]) |=> !b_pull_dn[g]); // R6
        AST_CONFLICT_NO_REV: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_a2b[g] && dir_b2a[g] && !a_pull_dn[g]) |=> !a_pull_dn[g]); // R6
    end
endmodule

// File: tb/hs_strobe_fwd_tb_top.sv
module hs_strobe_fwd_tb_top;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] a_strobe_n = '1, b_strobe_n = '1;
    logic [NS-1:0] a_self_drv = '0, b_self_drv = '0;
    logic [NS-1:0] dir_a2b = '0, dir_b2a = '0;
    logic [NS-1:0] a_pull_dn, b_pull_dn;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hs_strobe_fwd #(.NUM_STROBES(NS), .HOLD_CYC(6), .MIN_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_strobe_n(a_strobe_n), .b_strobe_n(b_strobe_n),
        .a_self_drv(a_self_drv), .b_self_drv(b_self_drv), .dir_a2b(dir_a2b),
        .dir_b2a(dir_b2a), .a_pull_dn(a_pull_dn), .b_pull_dn(b_pull_dn)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Fields: [12] strobe index, [11] direction (0 = A to B, 1 = B to A),
    // [10:6] input pulse length in ticks, [5:1] sample tick, [0] expected output.
    localparam logic [12:0] VEC [13] = '{
        {1'b0, 1'b0, 5'd1,  5'd2,  1'b0},   // R1 latency: not yet
        {1'b0, 1'b0, 5'd1,  5'd3,  1'b1},   // R1 third edge
        {1'b0, 1'b0, 5'd1,  5'd8,  1'b1},   // R4 held
        {1'b0, 1'b0, 5'd1,  5'd9,  1'b0},   // R4 window end
        {1'b0, 1'b0, 5'd7,  5'd9,  1'b1},   // R4 follow past window
        {1'b0, 1'b0, 5'd7,  5'd10, 1'b0},   // R7
        {1'b0, 1'b0, 5'd10, 5'd12, 1'b1},   // R7
        {1'b0, 1'b0, 5'd10, 5'd13, 1'b0},   // R7
        {1'b1, 1'b0, 5'd1,  5'd9,  1'b0},   // R1 ack A to B
        {1'b0, 1'b1, 5'd1,  5'd7,  1'b1},   // R5 stretched
        {1'b0, 1'b1, 5'd1,  5'd8,  1'b0},   // R5 end
        {1'b1, 1'b1, 5'd2,  5'd7,  1'b1},   // R1 ack B to A, R5
        {1'b0, 1'b1, 5'd10, 5'd13, 1'b0}    // R7 B to A
    };

    task automatic run_vec(int idx, bit dir, int len, int chk, logic exp, string tag);
        if (dir) dir_b2a[idx] = 1'b1; else dir_a2b[idx] = 1'b1;
        for (int t = 0; t < 24; t++) begin
            if (t == chk) check(tag, dir ? a_pull_dn[idx] : b_pull_dn[idx], exp);
            if (t == 0)   begin if (dir) b_strobe_n[idx] = 1'b0; else a_strobe_n[idx] = 1'b0; end
            if (t == len) begin if (dir) b_strobe_n[idx] = 1'b1; else a_strobe_n[idx] = 1'b1; end
            tick();
        end
        dir_a2b = '0;
        dir_b2a = '0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check("R8 reset a side", |a_pull_dn, 1'b0);
        check("R8 reset b side", |b_pull_dn, 1'b0);
        rst_n = 1'b1;
        tick();

        for (int v = 0; v < 13; v++) begin
            run_vec(int'(VEC[v][12]), VEC[v][11], int'(VEC[v][10:6]),
                    int'(VEC[v][5:1]), VEC[v][0], $sformatf("R1/R4/R5/R7 vector %0d", v));
        end

        // R2: no enable, no forwarding in either direction
        a_strobe_n = '0; b_strobe_n = '0;
        repeat (6) tick();
        check("R2 a2b disabled", |b_pull_dn, 1'b0);
        check("R2 b2a disabled", |a_pull_dn, 1'b0);
        a_strobe_n = '1; b_strobe_n = '1;
        repeat (4) tick();

        // R3: source-side self-drive blocks forwarding
        a_self_drv[0] = 1'b1; b_self_drv[1] = 1'b1;
        dir_a2b[0] = 1'b1; dir_b2a[1] = 1'b1;
        a_strobe_n[0] = 1'b0; b_strobe_n[1] = 1'b0;
        repeat (6) tick();
        check("R3 self-drive side A", b_pull_dn[0], 1'b0);
        check("R3 self-drive side B", a_pull_dn[1], 1'b0);
        a_strobe_n = '1; b_strobe_n = '1; a_self_drv = '0; b_self_drv = '0;
        dir_a2b = '0; dir_b2a = '0;
        repeat (4) tick();

        // R6: both enables active
        dir_a2b[1] = 1'b1; dir_b2a[1] = 1'b1;
        a_strobe_n[1] = 1'b0; b_strobe_n[1] = 1'b0;
        repeat (6) tick();
        check("R6 conflict a2b", b_pull_dn[1], 1'b0);
        check("R6 conflict b2a", a_pull_dn[1], 1'b0);
        a_strobe_n = '1; b_strobe_n = '1; dir_a2b = '0; dir_b2a = '0;
        repeat (4) tick();

        // R9: enable dropped inside hold window aborts A to B
        dir_a2b[0] = 1'b1; a_strobe_n[0] = 1'b0;
        repeat (4) tick();
        check("R9 before drop", b_pull_dn[0], 1'b1);
        dir_a2b[0] = 1'b0;
        tick();
        check("R9 after drop", b_pull_dn[0], 1'b0);
        a_strobe_n = '1;
        repeat (6) tick();

        // R5: enable dropped inside stretch window is ignored
        dir_b2a[0] = 1'b1; b_strobe_n[0] = 1'b0;
        repeat (4) tick();
        dir_b2a[0] = 1'b0; b_strobe_n[0] = 1'b1;
        repeat (3) tick();
        check("R5 stretch survives enable drop", a_pull_dn[0], 1'b1);
        tick();
        check("R5 stretch ends", a_pull_dn[0], 1'b0);
        repeat (4) tick();

        // R8: reset in the middle of a pulse
        dir_a2b[1] = 1'b1; a_strobe_n[1] = 1'b0;
        repeat (5) tick();
        check("R8 pulse active", b_pull_dn[1], 1'b1);
        #2 rst_n = 1'b0;
        #1 check("R8 async clear", b_pull_dn[1], 1'b0);
        tick();
        a_strobe_n = '1; dir_a2b = '0;
        tick();
        rst_n = 1'b1;
        repeat (3) tick();
        check("R8 stays clear", b_pull_dn[1], 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule